// File: doc/BRIEF.md
# Processor exception control unit

This unit is the exception half of the system coprocessor in a small 32-bit core. It holds three registers: a mode and mask word, a cause word and a saved return address. It watches four synchronous trap requests from the pipeline and six external interrupt lines. When an exception is taken, the unit does five things in the same cycle:

- tells the fetch unit to redirect to a fixed handler address;
- saves the faulting PC;
- records why the exception happened;
- switches to kernel mode;
- turns interrupts off.

It does not lose the previous mode and enable bit. A three-deep stack of (user-mode, interrupt-enable) pairs in the mode word shifts up on entry. It shifts back down on the return-from-exception strobe, which also redirects fetch to the saved address.

Software reaches the three registers through a single-cycle read/write port driven by move-to and move-from coprocessor instructions. Reads are combinational. Writes land on the clock edge. The interrupt lines are asynchronous and pass through a synchronizer before they show in the cause word.

Top module: `exc_ctrl`

## Requirements
- R1: Any trap input high makes redirect_o=1 and target_o=HANDLER_ADDR in the same cycle, and at the next edge the saved-PC register (index 14, also on epc_o) holds pc_i.
- R2: The exception code lands in cause bits 6:2, with bit 7 and bits 1:0 reading zero. Trap codes are: reserved instruction 10, load address error 4, overflow 12, syscall 8. When several traps are high together, the priority is reserved instruction, then address error, then overflow, then syscall.
- R3: Mode word layout: bit 0 is the current interrupt enable, bit 1 is the current user flag (0 = kernel), bits 3:2 are the previous pair, bits 5:4 are the older pair, and bits 15:8 are the mask. On entry, bits 5:2 take the old bits 3:0 and bits 1:0 become 00.
- R4: When eret_i is high and no exception is taken, bits 3:0 take the old bits 5:2, bits 5:4 keep their value, redirect_o=1 and target_o equals the saved-PC register.
- R5: Cause bits 15:10 show irq_i[5:0] delayed by two clock edges, and software writes to them are ignored.
- R6: An interrupt is taken, with code 0, only when mode bit 0 is 1 and some cause bit k in 15:8 has mode-word bit k set. Otherwise no redirect happens.
- R7: A trap and an enabled interrupt in the same cycle record the trap's code.
- R8: The register port has three indices. Index 12 is the mode word, where only bits 15:8 and 5:0 are writable and writes take effect only while bit 1 is 0. Index 13 is the cause word. Index 14 is the saved PC, writable at any time. All other indices read zero.
- R9: Only cause bits 9:8 (software interrupts) are writable, and they raise interrupts through mask bits 9:8.
- R10: An exception taken in the same cycle as a port write or eret_i wins. It saves pc_i, pushes the stack and sets target_o to the handler.
- R11: After reset, all three registers read zero and redirect_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pc_i | input | 32 | PC of the instruction in the exception stage |
| trap_ri_i | input | 1 | Reserved instruction trap |
| trap_adel_i | input | 1 | Unaligned load address trap |
| trap_ovf_i | input | 1 | Arithmetic overflow trap |
| trap_sys_i | input | 1 | Syscall trap |
| irq_i | input | 6 | Asynchronous external interrupt lines |
| eret_i | input | 1 | Return from exception |
| cp_we_i | input | 1 | Coprocessor register write strobe |
| cp_addr_i | input | 5 | Coprocessor register index |
| cp_wdata_i | input | 32 | Coprocessor write data |
| cp_rdata_o | output | 32 | Coprocessor read data (combinational) |
| redirect_o | output | 1 | Fetch redirect request |
| target_o | output | 32 | Redirect target address |
| epc_o | output | 32 | Saved exception PC |

## Verification
The bench uses the default parameters: 32-bit data, handler at 0x8000_0080 and a two-stage synchronizer. With two stages, the exact edge at which an external line first shows in the cause word can be checked, not just its eventual arrival. The 32-bit width lets the bench save and compare full addresses. The fixed handler value lets it tell a handler redirect apart from an eret redirect to a saved PC.

// File: rtl/exc_pkg.sv
package exc_pkg;
  localparam int unsigned NUM_HW   = 6;
  localparam int unsigned NUM_SW   = 2;
  localparam int unsigned NUM_PEND = NUM_HW + NUM_SW;
  localparam int unsigned CODE_W   = 5;
  localparam int unsigned STACK_W  = 6;
  localparam int unsigned ADDR_W   = 5;

  localparam logic [ADDR_W-1:0] IDX_STATUS = 5'd12;
  localparam logic [ADDR_W-1:0] IDX_CAUSE  = 5'd13;
  localparam logic [ADDR_W-1:0] IDX_EPC    = 5'd14;

  typedef enum logic [CODE_W-1:0] {
    EXC_INT  = 5'd0,
    EXC_ADEL = 5'd4,
    EXC_SYS  = 5'd8,
    EXC_RI   = 5'd10,
    EXC_OV   = 5'd12
  } exc_code_e;
endpackage

// File: rtl/exc_sync.sv
module exc_sync #(
  parameter int unsigned W      = 6,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg_q[s] <= '0;
        else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/exc_arb.sv
module exc_arb
  import exc_pkg::*;
(
  input  logic                trap_ri_i,
  input  logic                trap_adel_i,
  input  logic                trap_ovf_i,
  input  logic                trap_sys_i,
  input  logic [NUM_PEND-1:0] pend_i,
  input  logic [NUM_PEND-1:0] mask_i,
  input  logic                ie_i,
  output logic                take_o,
  output logic [CODE_W-1:0]   code_o
);
  logic irq_ok;

  assign irq_ok = ie_i && |(pend_i & mask_i);

  // traps outrank interrupts; fixed order among traps
  always_comb begin
    take_o = 1'b1;
    if (trap_ri_i)        code_o = EXC_RI;
    else if (trap_adel_i) code_o = EXC_ADEL;
    else if (trap_ovf_i)  code_o = EXC_OV;
    else if (trap_sys_i)  code_o = EXC_SYS;
    else begin
      code_o = EXC_INT;
      take_o = irq_ok;
    end
  end
endmodule

// File: rtl/exc_regs.sv
module exc_regs
  import exc_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              take_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              eret_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [XLEN-1:0]   wdata_i,
  input  logic [NUM_HW-1:0] hw_i,
  output logic [XLEN-1:0]   rdata_o,
  output logic [XLEN-1:0]   status_o,
  output logic [XLEN-1:0]   cause_o,
  output logic [XLEN-1:0]   epc_o
);
  localparam int unsigned MASK_LO = 8;
  localparam int unsigned SW_LO   = 8;
  localparam int unsigned HW_LO   = SW_LO + NUM_SW;

  logic [STACK_W-1:0]  stack_q;
  logic [NUM_PEND-1:0] mask_q;
  logic [NUM_SW-1:0]   sw_q;
  logic [CODE_W-1:0]   code_q;
  logic [XLEN-1:0]     epc_q;
  logic                kernel;
  logic                wr_status, wr_cause, wr_epc;

  assign kernel    = ~stack_q[1];
  assign wr_status = we_i && addr_i == IDX_STATUS && kernel && !take_i && !eret_i;
  assign wr_cause  = we_i && addr_i == IDX_CAUSE && !take_i;
  assign wr_epc    = we_i && addr_i == IDX_EPC && !take_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stack_q <= '0;
      mask_q  <= '0;
    end else if (take_i) begin
      stack_q <= {stack_q[3:0], 2'b00};
    end else if (eret_i) begin
      stack_q <= {stack_q[5:4], stack_q[5:2]};
    end else if (wr_status) begin
      stack_q <= wdata_i[STACK_W-1:0];
      mask_q  <= wdata_i[MASK_LO +: NUM_PEND];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q <= '0;
      sw_q   <= '0;
    end else begin
      if (take_i)   code_q <= code_i;
      if (wr_cause) sw_q   <= wdata_i[SW_LO +: NUM_SW];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     epc_q <= '0;
    else if (take_i) epc_q <= pc_i;
    else if (wr_epc) epc_q <= wdata_i;
  end

  always_comb begin
    status_o = '0;
    status_o[STACK_W-1:0]          = stack_q;
    status_o[MASK_LO +: NUM_PEND]  = mask_q;
    cause_o = '0;
    cause_o[2 +: CODE_W]           = code_q;
    cause_o[SW_LO +: NUM_SW]       = sw_q;
    cause_o[HW_LO +: NUM_HW]       = hw_i;
  end

  assign epc_o = epc_q;

  always_comb begin
    unique case (addr_i)
      IDX_STATUS: rdata_o = status_o;
      IDX_CAUSE:  rdata_o = cause_o;
      IDX_EPC:    rdata_o = epc_q;
      default:    rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int unsigned     XLEN         = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080,
  parameter int unsigned     SYNC_STAGES  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [XLEN-1:0]   pc_i,
  input  logic              trap_ri_i,
  input  logic              trap_adel_i,
  input  logic              trap_ovf_i,
  input  logic              trap_sys_i,
  input  logic [NUM_HW-1:0] irq_i,
  input  logic              eret_i,
  input  logic              cp_we_i,
  input  logic [ADDR_W-1:0] cp_addr_i,
  input  logic [XLEN-1:0]   cp_wdata_i,
  output logic [XLEN-1:0]   cp_rdata_o,
  output logic              redirect_o,
  output logic [XLEN-1:0]   target_o,
  output logic [XLEN-1:0]   epc_o
);
  logic [NUM_HW-1:0] hw_sync;
  logic [XLEN-1:0]   status_w, cause_w;
  logic              exc_take;
  logic [CODE_W-1:0] exc_code;

  exc_sync #(.W(NUM_HW), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (hw_sync)
  );

  exc_arb u_arb (
    .trap_ri_i  (trap_ri_i),
    .trap_adel_i(trap_adel_i),
    .trap_ovf_i (trap_ovf_i),
    .trap_sys_i (trap_sys_i),
    .pend_i     (cause_w[15:8]),
    .mask_i     (status_w[15:8]),
    .ie_i       (status_w[0]),
    .take_o     (exc_take),
    .code_o     (exc_code)
  );

  exc_regs #(.XLEN(XLEN)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .take_i  (exc_take),
    .code_i  (exc_code),
    .pc_i    (pc_i),
    .eret_i  (eret_i),
    .we_i    (cp_we_i),
    .addr_i  (cp_addr_i),
    .wdata_i (cp_wdata_i),
    .hw_i    (hw_sync),
    .rdata_o (cp_rdata_o),
    .status_o(status_w),
    .cause_o (cause_w),
    .epc_o   (epc_o)
  );

  assign redirect_o = exc_take | eret_i;
  assign target_o   = exc_take ? HANDLER_ADDR : epc_o;
endmodule

// File: rtl/exc_ctrl_chk.sv
module exc_ctrl_chk #(
  parameter int unsigned     XLEN         = 32,
  parameter logic [XLEN-1:0] HANDLER_ADDR = 32'h8000_0080
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            trap_ri_i,
  input logic            trap_adel_i,
  input logic            trap_ovf_i,
  input logic            trap_sys_i,
  input logic            eret_i,
  input logic [XLEN-1:0] pc_i,
  input logic            exc_take,
  input logic [XLEN-1:0] status_w,
  input logic [XLEN-1:0] epc_o,
  input logic            redirect_o,
  input logic [XLEN-1:0] target_o
);
  logic any_trap;
  assign any_trap = trap_ri_i | trap_adel_i | trap_ovf_i | trap_sys_i;

  // R1
  trap_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_trap |-> (redirect_o && target_o == HANDLER_ADDR));

  // R1
  epc_save_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> epc_o == $past(pc_i));

  // R3
  entry_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_take |=> status_w[5:0] == {$past(status_w[3:0]), 2'b00});

  // R4
  eret_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_take) |=> status_w[5:0] == {$past(status_w[5:4]), $past(status_w[5:2])});

  // R4
  eret_target_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eret_i && !exc_take) |-> (redirect_o && target_o == epc_o));

  // R6
  ie_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_w[0] && !any_trap) |-> !exc_take);
endmodule

bind exc_ctrl exc_ctrl_chk #(.XLEN(XLEN), .HANDLER_ADDR(HANDLER_ADDR)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trap_ri_i  (trap_ri_i),
  .trap_adel_i(trap_adel_i),
  .trap_ovf_i (trap_ovf_i),
  .trap_sys_i (trap_sys_i),
  .eret_i     (eret_i),
  .pc_i       (pc_i),
  .exc_take   (exc_take),
  .status_w   (status_w),
  .epc_o      (epc_o),
  .redirect_o (redirect_o),
  .target_o   (target_o)
);

// File: tb/exc_ctrl_test.sv
`timescale 1ns/1ps
module exc_ctrl_test;
  localparam logic [31:0] HND = 32'h8000_0080;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] pc_i = '0;
  logic        trap_ri_i = 0, trap_adel_i = 0, trap_ovf_i = 0, trap_sys_i = 0;
  logic [5:0]  irq_i = '0;
  logic        eret_i = 0;
  logic        cp_we_i = 0;
  logic [4:0]  cp_addr_i = '0;
  logic [31:0] cp_wdata_i = '0;
  logic [31:0] cp_rdata_o, target_o, epc_o;
  logic        redirect_o;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  exc_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .pc_i(pc_i),
    .trap_ri_i(trap_ri_i), .trap_adel_i(trap_adel_i),
    .trap_ovf_i(trap_ovf_i), .trap_sys_i(trap_sys_i),
    .irq_i(irq_i), .eret_i(eret_i),
    .cp_we_i(cp_we_i), .cp_addr_i(cp_addr_i), .cp_wdata_i(cp_wdata_i),
    .cp_rdata_o(cp_rdata_o), .redirect_o(redirect_o),
    .target_o(target_o), .epc_o(epc_o)
  );

  // {ri, adel, ovf, sys, expected code}
  localparam logic [7:0] VEC [8] = '{
    8'b0001_1000, 8'b0010_1100, 8'b0100_0100, 8'b1000_1010,
    8'b0011_1100, 8'b0110_0100, 8'b1111_1010, 8'b1001_1010
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    cp_addr_i = a;
    #0.5;
    d = cp_rdata_o;
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    cp_we_i = 1; cp_addr_i = a; cp_wdata_i = d;
    step();
    cp_we_i = 0;
  endtask

  task automatic set_traps(input logic [3:0] t);
    {trap_ri_i, trap_adel_i, trap_ovf_i, trap_sys_i} = t;
  endtask

  initial begin
    #(5.0 * 20000);
    bad++; total++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk);
    rst_ni = 1;
    @(negedge clk);

    // R11 reset state
    rd(12, d); check("R11 status", d, 0);
    rd(13, d); check("R11 cause", d, 0);
    rd(14, d); check("R11 epc", d, 0);
    check("R11 redirect", {31'b0, redirect_o}, 0);

    // R1 R2 trap table
    for (int i = 0; i < 8; i++) begin
      set_traps(VEC[i][7:4]);
      pc_i = 32'h1000 + 32'(i * 16);
      #0.5;
      check("R1 redirect", {31'b0, redirect_o}, 1);
      check("R1 target", target_o, HND);
      step();
      set_traps(4'b0);
      rd(13, d); check("R2 cause code", d, {26'b0, VEC[i][3:0], 2'b00});
      rd(14, d); check("R1 epc", d, 32'h1000 + 32'(i * 16));
    end

    // R3 R4 stack push/pop
    wr(12, 32'h3); rd(12, d); check("R8 status write", d, 32'h3);
    set_traps(4'b0001); pc_i = 32'h100; step();
    rd(12, d); check("R3 push once", d, 32'h0C);
    pc_i = 32'h200; step(); set_traps(4'b0);
    rd(12, d); check("R3 push twice", d, 32'h30);
    eret_i = 1; #0.5;
    check("R4 eret redirect", {31'b0, redirect_o}, 1);
    check("R4 eret target", target_o, 32'h200);
    step();
    rd(12, d); check("R4 pop once", d, 32'h3C);
    step(); eret_i = 0;
    rd(12, d); check("R4 pop twice", d, 32'h3F);

    // R8 user mode write ignored, epc writable, unmapped index
    wr(12, 32'h0); rd(12, d); check("R8 user status write ignored", d, 32'h3F);
    wr(14, 32'h1234_5670); rd(14, d); check("R8 epc write", d, 32'h1234_5670);
    rd(5, d); check("R8 unmapped reads zero", d, 0);

    // R5 synchronizer delay, R6 masked line does not redirect
    irq_i = 6'b000100;
    step(); rd(13, d); check("R5 one edge", d, 32'h20);
    step(); rd(13, d); check("R5 two edges", d, 32'h1020);
    check("R6 masked no redirect", {31'b0, redirect_o}, 0);

    set_traps(4'b0001); pc_i = 32'h2F0; step(); set_traps(4'b0);
    rd(12, d); check("R3 kernel again", d, 32'h3C);
    wr(12, 32'h103C); rd(12, d); check("R8 mask write", d, 32'h103C);
    check("R6 ie off no redirect", {31'b0, redirect_o}, 0);
    wr(12, 32'h103D);
    pc_i = 32'h300; #0.5;
    check("R6 int redirect", {31'b0, redirect_o}, 1);
    check("R6 int target", target_o, HND);
    step();
    rd(13, d); check("R6 int code", d, 32'h1000);
    rd(14, d); check("R6 int epc", d, 32'h300);
    rd(12, d); check("R6 int push", d, 32'h1034);

    // R7 trap beats pending interrupt
    wr(12, 32'h1035);
    set_traps(4'b0010); pc_i = 32'h400; step(); set_traps(4'b0);
    rd(13, d); check("R7 trap code wins", d, 32'h1030);
    rd(12, d); check("R7 status", d, 32'h1014);

    // R10 entry beats port write and eret
    set_traps(4'b0001); pc_i = 32'h500;
    cp_we_i = 1; cp_addr_i = 14; cp_wdata_i = 32'hDEAD_0000;
    step(); cp_we_i = 0;
    rd(14, d); check("R10 epc from pc", d, 32'h500);
    rd(12, d); check("R10 status", d, 32'h1010);
    eret_i = 1; pc_i = 32'h600; #0.5;
    check("R10 target handler", target_o, HND);
    step(); eret_i = 0; set_traps(4'b0);
    rd(12, d); check("R10 push not pop", d, 32'h1000);
    rd(14, d); check("R10 epc", d, 32'h600);

    // R5 R9 writable bits, software interrupt
    irq_i = '0; step(); step();
    wr(13, 32'hFFFF_FFFF); rd(13, d); check("R9 R5 cause write", d, 32'h320);
    wr(12, 32'h0101);
    pc_i = 32'h700; #0.5;
    check("R9 sw int redirect", {31'b0, redirect_o}, 1);
    step();
    rd(13, d); check("R9 sw int code", d, 32'h300);
    rd(14, d); check("R9 epc", d, 32'h700);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule